// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block decides whether a compute core can accept one more thread block. A dispatcher offers a block described by two numbers: how many threads it has and how many registers each thread needs. The controller holds three budgets: thread slots, block slots and registers in the register file. It admits the block only if all three budgets can hold it at the same moment. Whichever budget runs out first sets the occupancy, so small blocks tend to hit the block-slot limit and register-hungry blocks hit the register limit. No resource is split into fixed shares.

An admitted block is given a slot number, and its cost is taken out of the budgets. When the block finishes, the dispatcher names that slot on a completion port and the cost is given back. Each decision comes back one cycle after the request. A refused request carries a code that names the budget that refused it. The current totals in use are visible on the occupancy outputs at all times.

Top module: `sm_block_admit`

## Requirements
- R1: After reset no slot is busy, `used_blocks`, `used_threads` and `used_regs` are zero, and `resp_valid` is low.
- R2: A request with zero threads, or with more than THREAD_SLOTS (1536) threads, is refused with reason code 1 (bad request) and changes no budget.
- R3: A valid request made while all BLOCK_SLOTS (8) slots are busy is refused with reason code 2 (no block slot). For example, with 128-thread blocks only 8 are admitted, using 1024 threads.
- R4: A valid request whose threads, added to `used_threads`, would exceed 1536 is refused with reason code 3 (no thread slots). For example, with 512-thread blocks only 3 are admitted.
- R5: A block needs threads × registers-per-thread registers. A request whose need, added to `used_regs`, would exceed 16384 is refused with reason code 4 (no registers). With 10 registers per thread and 256 threads, 6 blocks are admitted using 15360 registers. With 12 registers per thread, 5 blocks are admitted, holding 1280 threads.
- R6: When more than one cause applies, the reported code follows the priority bad request > no block slot > no thread slots > no registers.
- R7: An admitted request returns `resp_ok`=1, reason code 0, and `resp_slot` equal to the lowest-numbered slot that was free. The slot becomes busy, and its threads and registers are added to the occupancy outputs.
- R8: For every cycle with `req_valid` high, `resp_valid` is high in the next cycle. Otherwise `resp_valid` is low.
- R9: A completion naming a busy slot returns that slot's threads and registers and frees the slot, visible one cycle later. A completion naming an idle slot changes nothing.
- R10: When an admission and a completion fall in the same cycle, the admission is judged against the budgets as they stood before that completion. The freed slot, threads and registers become usable from the next cycle.
- R11: `used_blocks` always equals the number of busy bits in `slot_busy`, and the occupancy outputs equal the sums over the busy slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Admission request this cycle |
| req_threads | input | 11 | Threads in the offered block |
| req_rpt | input | 7 | Registers per thread of the offered block |
| done_valid | input | 1 | A resident block has finished |
| done_slot | input | 3 | Slot of the finished block |
| resp_valid | output | 1 | Decision for the previous cycle's request |
| resp_ok | output | 1 | Request was admitted |
| resp_reason | output | 3 | 0 ok, 1 bad request, 2 no block slot, 3 no thread slots, 4 no registers |
| resp_slot | output | 3 | Slot given to an admitted block |
| slot_busy | output | 8 | One bit per resident slot |
| used_blocks | output | 4 | Resident block count |
| used_threads | output | 11 | Thread slots in use |
| used_regs | output | 15 | Registers in use |

## Verification
The decision for a request, and the occupancy change it causes, both appear one clock edge after the cycle in which the request is driven. A completion is also seen in the occupancy one edge later. The bench drives each cycle's inputs at a falling edge and compares all outputs at the next falling edge, after exactly one rising edge. In that comparison the reference model has already applied that cycle's admission and completion. For R10, the model judges the request against its state before it applies the completion.

// File: rtl/sm_admit_pkg.sv
package sm_admit_pkg;
  typedef enum logic [2:0] {
    ADM_OK         = 3'd0,
    ADM_BAD_REQ    = 3'd1,
    ADM_NO_SLOT    = 3'd2,
    ADM_NO_THREADS = 3'd3,
    ADM_NO_REGS    = 3'd4
  } adm_reason_e;
endpackage

// File: rtl/sm_adm_check.sv
module sm_adm_check #(
  parameter int THREAD_SLOTS = 1536,
  parameter int REG_FILE     = 16384,
  parameter int THR_W        = 11,
  parameter int RPT_W        = 7,
  parameter int UTH_W        = 11,
  parameter int URG_W        = 15,
  localparam int NEED_W      = THR_W + RPT_W
) (
  input  logic [THR_W-1:0]  req_threads,
  input  logic [RPT_W-1:0]  req_rpt,
  input  logic              slots_full,
  input  logic [UTH_W-1:0]  used_threads,
  input  logic [URG_W-1:0]  used_regs,
  output logic              ok,
  output logic [2:0]        reason,
  output logic [NEED_W-1:0] need_regs
);
  import sm_admit_pkg::*;

  localparam int CMP_W = NEED_W + 2;

  logic [CMP_W-1:0] thr_sum;
  logic [CMP_W-1:0] reg_sum;
  logic             bad_req;
  logic             thr_over;
  logic             reg_over;
  adm_reason_e      reason_e;

  always_comb begin
    need_regs = NEED_W'(req_threads) * NEED_W'(req_rpt);
    thr_sum   = CMP_W'(used_threads) + CMP_W'(req_threads);
    reg_sum   = CMP_W'(used_regs) + CMP_W'(need_regs);
    bad_req   = (req_threads == '0) || (CMP_W'(req_threads) > CMP_W'(THREAD_SLOTS));
    thr_over  = thr_sum > CMP_W'(THREAD_SLOTS);
    reg_over  = reg_sum > CMP_W'(REG_FILE);
    if (bad_req)         reason_e = ADM_BAD_REQ;
    else if (slots_full) reason_e = ADM_NO_SLOT;
    else if (thr_over)   reason_e = ADM_NO_THREADS;
    else if (reg_over)   reason_e = ADM_NO_REGS;
    else                 reason_e = ADM_OK;
    ok     = (reason_e == ADM_OK);
    reason = reason_e;
  end
endmodule

// File: rtl/sm_adm_slot_table.sv
module sm_adm_slot_table #(
  parameter int BLOCK_SLOTS = 8,
  parameter int THR_W       = 11,
  parameter int URG_W       = 15,
  localparam int SLOT_W     = (BLOCK_SLOTS > 1) ? $clog2(BLOCK_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [THR_W-1:0]  alloc_thr,
  input  logic [URG_W-1:0]  alloc_regs,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_slot,
  output logic [BLOCK_SLOTS-1:0] busy,
  output logic              full,
  output logic [SLOT_W-1:0] first_free,
  output logic              free_hit,
  output logic [THR_W-1:0]  freed_thr,
  output logic [URG_W-1:0]  freed_regs
);
  logic [BLOCK_SLOTS-1:0] busy_q;
  logic [BLOCK_SLOTS-1:0] busy_d;
  logic [BLOCK_SLOTS-1:0] alloc_oh;
  logic [BLOCK_SLOTS-1:0] free_oh;
  logic [THR_W-1:0]       thr_q [BLOCK_SLOTS];
  logic [URG_W-1:0]       reg_q [BLOCK_SLOTS];

  always_comb begin
    first_free = '0;
    for (int i = BLOCK_SLOTS - 1; i >= 0; i--) begin
      if (!busy_q[i]) first_free = SLOT_W'(i);
    end
    full       = &busy_q;
    free_hit   = free_en && busy_q[free_slot];
    freed_thr  = thr_q[free_slot];
    freed_regs = reg_q[free_slot];
  end

  generate
    for (genvar s = 0; s < BLOCK_SLOTS; s++) begin : g_slot
      always_comb begin
        alloc_oh[s] = alloc_en && (first_free == SLOT_W'(s));
        free_oh[s]  = free_hit && (free_slot == SLOT_W'(s));
        busy_d[s]   = (busy_q[s] && !free_oh[s]) || alloc_oh[s];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          thr_q[s] <= '0;
          reg_q[s] <= '0;
        end else if (alloc_oh[s]) begin
          thr_q[s] <= alloc_thr;
          reg_q[s] <= alloc_regs;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;

  assert_alloc_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (!busy_q[first_free] && !full));
  assert_alloc_marks_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> busy_q[$past(first_free)]);
  assert_idle_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_en && !busy_q[free_slot] && !alloc_en) |=> $stable(busy_q));
endmodule

// File: rtl/sm_adm_usage.sv
module sm_adm_usage #(
  parameter int THREAD_SLOTS = 1536,
  parameter int REG_FILE     = 16384,
  parameter int BLOCK_SLOTS  = 8,
  parameter int UTH_W        = 11,
  parameter int URG_W        = 15,
  parameter int CNT_W        = 4,
  parameter int THR_W        = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [THR_W-1:0] add_thr,
  input  logic [URG_W-1:0] add_regs,
  input  logic             sub_en,
  input  logic [THR_W-1:0] sub_thr,
  input  logic [URG_W-1:0] sub_regs,
  output logic [UTH_W-1:0] used_threads,
  output logic [URG_W-1:0] used_regs,
  output logic [CNT_W-1:0] used_blocks
);
  logic [UTH_W-1:0] thr_q, thr_d;
  logic [URG_W-1:0] reg_q, reg_d;
  logic [CNT_W-1:0] blk_q, blk_d;
  logic             upd;

  always_comb begin
    upd   = add_en || sub_en;
    thr_d = thr_q;
    reg_d = reg_q;
    blk_d = blk_q;
    if (sub_en) begin
      thr_d = thr_d - UTH_W'(sub_thr);
      reg_d = reg_d - sub_regs;
      blk_d = blk_d - CNT_W'(1);
    end
    if (add_en) begin
      thr_d = thr_d + UTH_W'(add_thr);
      reg_d = reg_d + add_regs;
      blk_d = blk_d + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      reg_q <= '0;
      blk_q <= '0;
    end else if (upd) begin
      thr_q <= thr_d;
      reg_q <= reg_d;
      blk_q <= blk_d;
    end
  end

  assign used_threads = thr_q;
  assign used_regs    = reg_q;
  assign used_blocks  = blk_q;

  assert_thread_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(thr_q) <= THREAD_SLOTS);
  assert_reg_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(reg_q) <= REG_FILE);
  assert_block_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(blk_q) <= BLOCK_SLOTS);
endmodule

// File: rtl/sm_block_admit.sv
module sm_block_admit #(
  parameter int THREAD_SLOTS = 1536,
  parameter int BLOCK_SLOTS  = 8,
  parameter int REG_FILE     = 16384,
  parameter int THR_W        = 11,
  parameter int RPT_W        = 7,
  localparam int SLOT_W      = (BLOCK_SLOTS > 1) ? $clog2(BLOCK_SLOTS) : 1,
  localparam int CNT_W       = $clog2(BLOCK_SLOTS + 1),
  localparam int UTH_W       = $clog2(THREAD_SLOTS + 1),
  localparam int URG_W       = $clog2(REG_FILE + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [THR_W-1:0]       req_threads,
  input  logic [RPT_W-1:0]       req_rpt,
  input  logic                   done_valid,
  input  logic [SLOT_W-1:0]      done_slot,
  output logic                   resp_valid,
  output logic                   resp_ok,
  output logic [2:0]             resp_reason,
  output logic [SLOT_W-1:0]      resp_slot,
  output logic [BLOCK_SLOTS-1:0] slot_busy,
  output logic [CNT_W-1:0]       used_blocks,
  output logic [UTH_W-1:0]       used_threads,
  output logic [URG_W-1:0]       used_regs
);
  import sm_admit_pkg::*;

  localparam int NEED_W = THR_W + RPT_W;

  logic              chk_ok;
  logic [2:0]        chk_reason;
  logic [NEED_W-1:0] need_regs;
  logic              full;
  logic [SLOT_W-1:0] first_free;
  logic              free_hit;
  logic [THR_W-1:0]  freed_thr;
  logic [URG_W-1:0]  freed_regs;
  logic              admit;

  logic              rv_q, rv_d;
  logic              rok_q, rok_d;
  logic [2:0]        rrs_q, rrs_d;
  logic [SLOT_W-1:0] rsl_q, rsl_d;

  sm_adm_check #(
    .THREAD_SLOTS(THREAD_SLOTS), .REG_FILE(REG_FILE),
    .THR_W(THR_W), .RPT_W(RPT_W), .UTH_W(UTH_W), .URG_W(URG_W)
  ) u_check (
    .req_threads (req_threads),
    .req_rpt     (req_rpt),
    .slots_full  (full),
    .used_threads(used_threads),
    .used_regs   (used_regs),
    .ok          (chk_ok),
    .reason      (chk_reason),
    .need_regs   (need_regs)
  );

  assign admit = req_valid && chk_ok;

  sm_adm_slot_table #(
    .BLOCK_SLOTS(BLOCK_SLOTS), .THR_W(THR_W), .URG_W(URG_W)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (admit),
    .alloc_thr (req_threads),
    .alloc_regs(URG_W'(need_regs)),
    .free_en   (done_valid),
    .free_slot (done_slot),
    .busy      (slot_busy),
    .full      (full),
    .first_free(first_free),
    .free_hit  (free_hit),
    .freed_thr (freed_thr),
    .freed_regs(freed_regs)
  );

  sm_adm_usage #(
    .THREAD_SLOTS(THREAD_SLOTS), .REG_FILE(REG_FILE), .BLOCK_SLOTS(BLOCK_SLOTS),
    .UTH_W(UTH_W), .URG_W(URG_W), .CNT_W(CNT_W), .THR_W(THR_W)
  ) u_usage (
    .clk         (clk),
    .rst_n       (rst_n),
    .add_en      (admit),
    .add_thr     (req_threads),
    .add_regs    (URG_W'(need_regs)),
    .sub_en      (free_hit),
    .sub_thr     (freed_thr),
    .sub_regs    (freed_regs),
    .used_threads(used_threads),
    .used_regs   (used_regs),
    .used_blocks (used_blocks)
  );

  always_comb begin
    rv_d  = req_valid;
    rok_d = rok_q;
    rrs_d = rrs_q;
    rsl_d = rsl_q;
    if (req_valid) begin
      rok_d = chk_ok;
      rrs_d = chk_reason;
      rsl_d = chk_ok ? first_free : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= rv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rok_q <= 1'b0;
      rrs_q <= ADM_OK;
      rsl_q <= '0;
    end else if (req_valid) begin
      rok_q <= rok_d;
      rrs_q <= rrs_d;
      rsl_q <= rsl_d;
    end
  end

  assign resp_valid  = rv_q;
  assign resp_ok     = rok_q;
  assign resp_reason = rrs_q;
  assign resp_slot   = rsl_q;

  assert_resp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_no_spurious_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  assert_bad_req_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_threads == '0) |=> (!resp_ok && resp_reason == ADM_BAD_REQ));
  assert_count_matches_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used_blocks) == $countones(slot_busy));
  assert_full_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (&slot_busy)) |=> !resp_ok);
endmodule

// File: tb/sm_block_admit_bench.sv
module sm_block_admit_bench;
  localparam int TS = 1536;
  localparam int NB = 8;
  localparam int RF = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [10:0] req_threads = '0;
  logic [6:0]  req_rpt = '0;
  logic        done_valid = 1'b0;
  logic [2:0]  done_slot = '0;
  logic        resp_valid, resp_ok;
  logic [2:0]  resp_reason, resp_slot;
  logic [7:0]  slot_busy;
  logic [3:0]  used_blocks;
  logic [10:0] used_threads;
  logic [14:0] used_regs;

  sm_block_admit u_sm_block_admit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_rpt(req_rpt), .done_valid(done_valid), .done_slot(done_slot),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_reason(resp_reason),
    .resp_slot(resp_slot), .slot_busy(slot_busy), .used_blocks(used_blocks),
    .used_threads(used_threads), .used_regs(used_regs)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int m_busy [NB];
  int m_thr  [NB];
  int m_reg  [NB];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_sum(int which);
    int s = 0;
    for (int i = 0; i < NB; i++) begin
      if (m_busy[i] != 0) s += (which == 0) ? 1 : (which == 1) ? m_thr[i] : m_reg[i];
    end
    return s;
  endfunction

  task automatic compare_occ();
    int bm = 0;
    for (int i = 0; i < NB; i++) if (m_busy[i] != 0) bm |= (1 << i);
    chk("R11", "slot_busy", int'(slot_busy), bm);
    chk("R11", "used_blocks", int'(used_blocks), m_sum(0));
    chk("R11", "used_threads", int'(used_threads), m_sum(1));
    chk("R11", "used_regs", int'(used_regs), m_sum(2));
  endtask

  // One cycle: drive at falling edge, evaluate model, check at next falling edge.
  task automatic cyc(bit rv, int thr, int rpt, bit dv, int ds, string tag);
    int exp_reason = 0;
    int exp_slot = 0;
    req_valid = rv; req_threads = 11'(thr); req_rpt = 7'(rpt);
    done_valid = dv; done_slot = 3'(ds);
    if (rv) begin
      if (thr == 0 || thr > TS)               exp_reason = 1;
      else if (m_sum(0) == NB)                exp_reason = 2;
      else if (m_sum(1) + thr > TS)           exp_reason = 3;
      else if (m_sum(2) + thr * rpt > RF)     exp_reason = 4;
      if (exp_reason == 0) begin
        for (int i = NB - 1; i >= 0; i--) if (m_busy[i] == 0) exp_slot = i;
      end
    end
    if (dv && m_busy[ds] != 0) m_busy[ds] = 0;
    if (rv && exp_reason == 0) begin
      m_busy[exp_slot] = 1; m_thr[exp_slot] = thr; m_reg[exp_slot] = thr * rpt;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R8", "resp_valid", int'(resp_valid), int'(rv));
    if (rv) begin
      chk(tag, "resp_ok", int'(resp_ok), int'(exp_reason == 0));
      chk(tag, "resp_reason", int'(resp_reason), exp_reason);
      if (exp_reason == 0) chk("R7", "resp_slot", int'(resp_slot), exp_slot);
    end
    compare_occ();
    req_valid = 0; done_valid = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, "R8");
  endtask

  task automatic drain();
    for (int i = 0; i < NB; i++) cyc(0, 0, 0, 1, i, "R9");
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin m_busy[i] = 0; m_thr[i] = 0; m_reg[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "resp_valid", int'(resp_valid), 0);
    chk("R1", "used_blocks", int'(used_blocks), 0);
    chk("R1", "used_threads", int'(used_threads), 0);
    chk("R1", "used_regs", int'(used_regs), 0);
    chk("R1", "slot_busy", int'(slot_busy), 0);
    rst_n = 1;
    @(negedge clk);
    idle();

    // R2: bad requests
    cyc(1, 0, 4, 0, 0, "R2");
    cyc(1, 1537, 1, 0, 0, "R2");
    cyc(1, 1536, 1, 0, 0, "R7");   // largest legal request fills thread slots
    cyc(1, 1, 1, 0, 0, "R4");
    drain();

    // R3: 128-thread blocks stop at 8, 1024 threads
    for (int k = 0; k < 9; k++) cyc(1, 128, 4, 0, 0, (k < 8) ? "R7" : "R3");
    chk("R3", "threads at block limit", int'(used_threads), 1024);
    // R6: bad request beats full slots; full slots beat thread overflow
    cyc(1, 0, 1, 0, 0, "R6");
    cyc(1, 600, 1, 0, 0, "R6");
    // R9: free slot 3 then the next admit reuses slot 3 (lowest free)
    cyc(0, 0, 0, 1, 3, "R9");
    cyc(0, 0, 0, 1, 3, "R9");        // idle slot: ignored
    cyc(1, 64, 2, 0, 0, "R7");
    drain();
    cyc(0, 0, 0, 1, 5, "R9");        // completion on idle slot
    idle();

    // R5: 10 regs/thread, 256 threads -> 6 admitted, 15360 regs
    for (int k = 0; k < 7; k++) cyc(1, 256, 10, 0, 0, (k < 6) ? "R7" : "R6");
    chk("R5", "regs after six", int'(used_regs), 15360);
    // R10: free slot 0 with same-cycle request: threads still full
    cyc(1, 256, 1, 1, 0, "R10");
    cyc(1, 256, 1, 0, 0, "R10");
    drain();

    // R5: 12 regs/thread -> 5 admitted, 1280 threads, sixth refused on regs
    for (int k = 0; k < 6; k++) cyc(1, 256, 12, 0, 0, (k < 5) ? "R7" : "R5");
    chk("R5", "threads at reg limit", int'(used_threads), 1280);
    drain();

    // R4: 512-thread blocks -> 3 admitted
    for (int k = 0; k < 4; k++) cyc(1, 512, 1, 0, 0, (k < 3) ? "R7" : "R4");
    cyc(1, 256, 127, 0, 0, "R6");    // threads and regs both over: threads reported
    // R10: block slot reuse after same-cycle completion of slot 1
    cyc(1, 100, 1, 1, 1, "R10");
    cyc(1, 100, 1, 0, 0, "R10");
    drain();

    // mixed traffic with overlapping completions
    for (int k = 0; k < 40; k++) begin
      cyc(1, 32 + (k * 97) % 700, 1 + (k * 13) % 40, (k % 3) == 0, (k * 5) % NB, "R7");
    end
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule